// File: doc/BRIEF.md
# Network Controller Event Interrupt Aggregator

This block collects single-cycle event pulses from the transmit, receive and management logic of a network controller. It latches them into a 32-bit event register and qualifies them with a 32-bit mask register. The thirteen event flags sit in the top bits of the event register. Each flag has its own interrupt line, and the lines are ordered differently from the register bits. A line is high when its flag is set and its mask bit is set.

Software reaches both registers through a small register port. Writing the event register clears every flag whose bit in the written word is one. Writing the mask register replaces the whole word. A soft-clear input zeroes both registers. Each interrupt line is registered and is re-driven only when its own masked state has changed.

Top module: `nic_evt_irq`

## Requirements
- R1: After the synchronous reset `rst`, the event register, the mask register and all 13 lines of `irq` are zero.
- R2: A pulse on `evt_pulse[k]` (k = 0..12) sets event register bit 19+k on the next clock edge. The flags on bits 31..19 are, from high to low: heartbeat, babbling receive, babbling transmit, graceful stop, tx frame, tx buffer, rx frame, rx buffer, management done, bus error, late collision, retry limit, tx underrun. Event bits 18..0 always read zero.
- R3: A write with `reg_sel`=0 clears each event bit that is 1 in `reg_wdata` and leaves every other event bit unchanged.
- R4: If an event pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R5: A write with `reg_sel`=1 loads all 32 bits of `reg_wdata` into the mask register. `reg_rdata` shows the event register when `reg_sel`=0 and the mask register when `reg_sel`=1.
- R6: One clock after the registers change, `irq[i]` equals event AND mask for its event bit. For i = 0..12 that bit is 27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30.
- R7: `soft_clr` zeroes the event and mask registers on the next edge and takes priority over pulses and writes. All `irq` lines are low one clock later.
- R8: An `irq` line holds its value in any cycle in which its masked state did not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_clr | input | 1 | Clears the event and mask registers |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the event register, 1 selects the mask register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| evt_pulse | input | 13 | Event pulses, bit k sets event bit 19+k |
| irq | output | 13 | Per-event interrupt lines |

## Verification
The bench sets each event bit alone and checks that exactly the expected line rises. A design with a positional mapping, or with a swapped table entry, would raise the wrong line. It collides a pulse with a clearing write on the same bit. A design that lets the clear win would lose the event. It writes a clearing pattern that covers only some of the set flags, which catches a design that clears the whole register. It also masks a set flag and then unmasks it, checking that the line follows the mask while the event register stays unchanged.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;
  localparam int DATA_W  = 32;
  localparam int N_LINES = 13;
  localparam int EVT_LSB = DATA_W - N_LINES;

  // event-register bit that drives interrupt line i
  function automatic int line_bit(input int i);
    case (i)
      0:  line_bit = 27;
      1:  line_bit = 26;
      2:  line_bit = 19;
      3:  line_bit = 20;
      4:  line_bit = 25;
      5:  line_bit = 24;
      6:  line_bit = 23;
      7:  line_bit = 21;
      8:  line_bit = 31;
      9:  line_bit = 28;
      10: line_bit = 22;
      11: line_bit = 29;
      default: line_bit = 30;
    endcase
  endfunction
endpackage

// File: rtl/nic_evt_reg.sv
module nic_evt_reg #(
  parameter int DW  = 32,
  parameter int NEV = 13
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           soft_clr,
  input  logic           wr_en,
  input  logic [DW-1:0]  wdata,
  input  logic [NEV-1:0] set_pulse,
  output logic [DW-1:0]  evt_q
);
  localparam int LSB = DW - NEV;

  logic [DW-1:0] set_vec, clr_vec, evt_d;

  assign set_vec = DW'(set_pulse) << LSB;
  assign clr_vec = wr_en ? wdata : '0;
  // pulses override a same-cycle clear
  assign evt_d   = (evt_q & ~clr_vec) | set_vec;

  always_ff @(posedge clk) begin
    if (rst || soft_clr) evt_q <= '0;
    else                 evt_q <= evt_d;
  end

  always_comb begin
    if (!rst) p_rsvd_zero_r2: assert (evt_q[LSB-1:0] == '0);
  end

  p_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
    (!soft_clr && set_pulse != '0) |=> ((evt_q & $past(set_vec)) == $past(set_vec)));

  p_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (!soft_clr && wr_en) |=> ((evt_q & $past(wdata & ~set_vec)) == '0));

  p_keep_r3: assert property (@(posedge clk) disable iff (rst)
    (!soft_clr) |=> ((evt_q & $past(evt_q & ~clr_vec)) == $past(evt_q & ~clr_vec)));

  p_soft_evt_r7: assert property (@(posedge clk) disable iff (rst)
    soft_clr |=> (evt_q == '0));
endmodule

// File: rtl/nic_mask_reg.sv
module nic_mask_reg #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          soft_clr,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (rst || soft_clr) mask_q <= '0;
    else if (wr_en)      mask_q <= wdata;
  end

  p_mask_load_r5: assert property (@(posedge clk) disable iff (rst)
    (!soft_clr && wr_en) |=> (mask_q == $past(wdata)));

  p_soft_mask_r7: assert property (@(posedge clk) disable iff (rst)
    soft_clr |=> (mask_q == '0));
endmodule

// File: rtl/nic_irq_lines.sv
module nic_irq_lines
  import nic_irq_pkg::*;
#(
  parameter int DW  = 32,
  parameter int NEV = 13
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [DW-1:0]  evt,
  input  logic [DW-1:0]  mask,
  output logic [NEV-1:0] irq_q
);
  logic [NEV-1:0] active;

  for (genvar g = 0; g < NEV; g++) begin : g_line
    localparam int B = line_bit(g);
    assign active[g] = evt[B] & mask[B];

    // irq_q doubles as the stored previous active set
    always_ff @(posedge clk) begin
      if (rst)                      irq_q[g] <= 1'b0;
      else if (active[g] != irq_q[g]) irq_q[g] <= active[g];
    end
  end

  p_irq_follow_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_q == $past(active)));

  p_irq_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (active == irq_q) |=> $stable(irq_q));
endmodule

// File: rtl/nic_evt_irq.sv
module nic_evt_irq
  import nic_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               soft_clr,
  input  logic               reg_wr,
  input  logic               reg_sel,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [N_LINES-1:0] evt_pulse,
  output logic [N_LINES-1:0] irq
);
  logic [DATA_W-1:0] evt_q, mask_q;

  nic_evt_reg #(.DW(DATA_W), .NEV(N_LINES)) u_evt (
    .clk(clk), .rst(rst), .soft_clr(soft_clr),
    .wr_en(reg_wr && !reg_sel), .wdata(reg_wdata),
    .set_pulse(evt_pulse), .evt_q(evt_q));

  nic_mask_reg #(.DW(DATA_W)) u_mask (
    .clk(clk), .rst(rst), .soft_clr(soft_clr),
    .wr_en(reg_wr && reg_sel), .wdata(reg_wdata), .mask_q(mask_q));

  nic_irq_lines #(.DW(DATA_W), .NEV(N_LINES)) u_lines (
    .clk(clk), .rst(rst), .evt(evt_q), .mask(mask_q), .irq_q(irq));

  assign reg_rdata = reg_sel ? mask_q : evt_q;

  p_reset_r1: assert property (@(posedge clk) rst |=> (irq == '0));
endmodule

// File: tb/nic_evt_irq_bench.sv
module nic_evt_irq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        soft_clr = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [12:0] evt_pulse = '0;
  logic [12:0] irq;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  localparam int MAPB [13] = '{27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30};

  always #5 clk = ~clk;

  nic_evt_irq u_nic_evt_irq (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_sel = sel; reg_wdata = d;
    step(); reg_wr = 0;
  endtask

  task automatic pulse(input logic [12:0] v);
    @(negedge clk); evt_pulse = v;
    step(); evt_pulse = '0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] d);
    @(negedge clk); reg_sel = sel; #1; d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(0, d); chk("R1 event", d, 0);
    rd(1, d); chk("R1 mask", d, 0);
    chk("R1 irq", {19'd0, irq}, 0);
  endtask

  task automatic t_set();
    logic [31:0] d;
    for (int k = 0; k < 13; k++) begin
      pulse(13'(1) << k);
      rd(0, d); chk("R2 set bit", d, 32'(1) << (19 + k));
      wr(0, 32'hFFFF_FFFF);
    end
    pulse('1);
    wr(0, 32'h0007_FFFF);
    rd(0, d); chk("R2 reserved zero", d, 32'hFFF8_0000);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(0, 32'h5555_5555);
    rd(0, d); chk("R3 partial clear", d, 32'hAAA8_0000);
    wr(0, 32'hFFFF_FFFF);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    pulse(13'h0101);
    @(negedge clk); reg_wr = 1; reg_sel = 0; reg_wdata = 32'hFFFF_FFFF; evt_pulse = 13'h0001;
    step(); reg_wr = 0; evt_pulse = '0;
    rd(0, d); chk("R4 set wins", d, 32'h0008_0000);
    wr(0, 32'hFFFF_FFFF);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(1, 32'h1234_5678);
    rd(1, d); chk("R5 mask load", d, 32'h1234_5678);
    wr(1, 32'h0000_00F0);
    rd(1, d); chk("R5 mask replace", d, 32'h0000_00F0);
  endtask

  task automatic t_map();
    wr(1, 32'hFFFF_FFFF);
    for (int i = 0; i < 13; i++) begin
      pulse(13'(1) << (MAPB[i] - 19));
      step();
      chk("R6 line map", {19'd0, irq}, 32'(1) << i);
      wr(0, 32'hFFFF_FFFF);
      step();
    end
  endtask

  task automatic t_masking();
    logic [31:0] d;
    pulse(13'h0100);
    wr(1, 32'h0000_0000); step();
    chk("R6 masked line low", {19'd0, irq}, 0);
    rd(0, d); chk("R8 event kept", d, 32'h0800_0000);
    step(); chk("R8 line held", {19'd0, irq}, 0);
    wr(1, 32'h0800_0000); step();
    chk("R6 unmasked line", {19'd0, irq}, 1);
  endtask

  task automatic t_soft();
    logic [31:0] d;
    @(negedge clk); soft_clr = 1; evt_pulse = 13'h1FFF;
    step(); soft_clr = 0; evt_pulse = '0;
    rd(0, d); chk("R7 event cleared", d, 0);
    rd(1, d); chk("R7 mask cleared", d, 0);
    step(); chk("R7 irq low", {19'd0, irq}, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    t_reset();
    t_set();
    t_w1c();
    t_collide();
    t_mask();
    t_map();
    t_masking();
    t_soft();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule